// File: doc/BRIEF.md
# Quiet Floating-Point Compare and Min/Max Unit

This unit takes two binary floating-point operands (single precision by default, with the exponent and fraction widths as parameters) and applies one of five functions to them. Three of the functions are ordered compares: equal, greater-than and greater-or-equal. Each produces a one-bit predicate. The other two, minimum and maximum, produce a full-width operand. A three-bit operation code selects the function. A valid strobe captures the result into output registers one clock later.

The compares are quiet. They return false whenever a NaN is involved and never raise an exception flag. Minimum and maximum treat NaN operands as missing data. If one operand is NaN, the other operand is returned. If both are NaN, the result is the all-ones pattern. A signed zero is resolved by its sign bit. A sticky flag word records exceptions at fixed bit positions. Only a signaling-NaN operand to min/max raises one, the invalid flag. A clear input wipes the word.

Top module: `fpcm_top`

## Requirements
- R1: After reset, pred_o is 0, result_o is 0 and flags_o is 0. An operation presented with valid_i high appears on the outputs after the next rising clock edge. With valid_i low, all outputs hold their values.
- R2: Op code 0 (equal) sets pred_o to 1 exactly when both operands have the same numeric value. +0 equals -0. Any NaN operand gives 0.
- R3: Op code 1 (greater-than) and op code 2 (greater-or-equal) order non-NaN operands by value: sign first, then magnitude, with infinities at the ends and +0 equal to -0. Any NaN operand gives 0.
- R4: The compare ops (codes 0 to 2) never change flags_o, including when an operand is a quiet or a signaling NaN.
- R5: Op code 3 (min) and op code 4 (max) return the numerically smaller or larger operand. Between +0 and -0, min returns -0 and max returns +0.
- R6: When exactly one operand of min or max is NaN, result_o is the other operand unchanged.
- R7: When both operands of min or max are NaN, result_o is all ones.
- R8: A NaN has an all-ones exponent and a nonzero fraction. It is quiet when the fraction MSB is 1 and signaling otherwise. Min/max sets the invalid flag, flags_o bit 1, when either operand is a signaling NaN. Quiet NaNs leave it clear.
- R9: flags_o occupies bits 5:1 of the flag word. Bit 1 is invalid, bit 2 divide-by-zero, bit 3 overflow, bit 4 underflow and bit 5 inexact. No operation of this unit raises bits 2 to 5.
- R10: Flags are sticky: each operation ORs its new flags into the stored word. flag_clr_i zeroes the word at the next edge. When flag_clr_i and valid_i are high together, only the new operation's flags remain.
- R11: Compares leave result_o unchanged, and min/max leave pred_o unchanged. Op codes 5 to 7 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Capture the selected operation this cycle |
| op_i | input | 3 | Operation code (0 eq, 1 gt, 2 ge, 3 min, 4 max) |
| a_i | input | EXP_W+FRAC_W+1 | First operand |
| b_i | input | EXP_W+FRAC_W+1 | Second operand |
| flag_clr_i | input | 1 | Zero the sticky flag word |
| pred_o | output | 1 | Registered compare predicate |
| result_o | output | EXP_W+FRAC_W+1 | Registered min/max result |
| flags_o | output | 5 | Sticky exception flags, bits 5:1 |

## Verification
The main bench instance is built with a 3-bit exponent and a 2-bit fraction, a 6-bit format. With this format every operand pair (4096 of them) can be run through all five operations. That sweep covers both zeros, subnormals, infinities, and quiet and signaling NaNs against every other class. Each expected value is computed from a real-valued decode of the operand. A second instance at the default single-precision widths gets directed checks with the standard quiet and signaling NaN patterns, signed zeros and 1.0.

// File: rtl/fpcm_pkg.sv
package fpcm_pkg;

    typedef enum logic [2:0] {
        OP_EQ  = 3'd0,
        OP_GT  = 3'd1,
        OP_GE  = 3'd2,
        OP_MIN = 3'd3,
        OP_MAX = 3'd4
    } fpcm_op_e;

    localparam int FLAG_LO  = 1;
    localparam int FLAG_HI  = 5;
    localparam int FLAG_INV = 1;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
    } fpcm_class_t;

endpackage

// File: rtl/fpcm_classify.sv
module fpcm_classify
    import fpcm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] opnd_i,
    output fpcm_class_t           cls_o
);
    localparam int W = EXP_W + FRAC_W + 1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;
    logic              frac_nz;

    always_comb begin
        exp_f          = opnd_i[W-2 -: EXP_W];
        frac_f         = opnd_i[FRAC_W-1:0];
        exp_ones       = &exp_f;
        frac_nz        = |frac_f;
        cls_o.is_nan   = exp_ones && frac_nz;
        cls_o.is_snan  = exp_ones && frac_nz && !frac_f[FRAC_W-1];
    end

endmodule

// File: rtl/fpcm_order.sv
module fpcm_order #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] a_i,
    input  logic [EXP_W+FRAC_W:0] b_i,
    output logic                  eq_o,
    output logic                  gt_o,
    output logic                  a_before_b_o,
    output logic                  b_before_a_o
);
    localparam int W = EXP_W + FRAC_W + 1;

    logic         sa, sb;
    logic [W-2:0] ma, mb;
    logic         zeros;

    always_comb begin
        sa    = a_i[W-1];
        sb    = b_i[W-1];
        ma    = a_i[W-2:0];
        mb    = b_i[W-2:0];
        zeros = (ma == '0) && (mb == '0);

        eq_o = (a_i == b_i) || zeros;

        if (zeros)        gt_o = 1'b0;
        else if (sa != sb) gt_o = !sa;
        else if (!sa)     gt_o = ma > mb;
        else              gt_o = ma < mb;

        // sign-aware total order: -0 sorts before +0
        if (sa != sb)  a_before_b_o = sa;
        else if (!sa)  a_before_b_o = ma < mb;
        else           a_before_b_o = ma > mb;

        if (sa != sb)  b_before_a_o = sb;
        else if (!sa)  b_before_a_o = mb < ma;
        else           b_before_a_o = mb > ma;
    end

endmodule

// File: rtl/fpcm_select.sv
module fpcm_select
    import fpcm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] a_i,
    input  logic [EXP_W+FRAC_W:0] b_i,
    input  fpcm_class_t           cls_a_i,
    input  fpcm_class_t           cls_b_i,
    input  logic                  a_before_b_i,
    input  logic                  b_before_a_i,
    input  logic                  want_max_i,
    output logic [EXP_W+FRAC_W:0] pick_o
);
    always_comb begin
        if (cls_a_i.is_nan && cls_b_i.is_nan)
            pick_o = '1;
        else if (cls_a_i.is_nan)
            pick_o = b_i;
        else if (cls_b_i.is_nan)
            pick_o = a_i;
        else if (want_max_i)
            pick_o = a_before_b_i ? b_i : a_i;
        else
            pick_o = b_before_a_i ? b_i : a_i;
    end

endmodule

// File: rtl/fpcm_top.sv
module fpcm_top
    import fpcm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid_i,
    input  logic [2:0]            op_i,
    input  logic [EXP_W+FRAC_W:0] a_i,
    input  logic [EXP_W+FRAC_W:0] b_i,
    input  logic                  flag_clr_i,
    output logic                  pred_o,
    output logic [EXP_W+FRAC_W:0] result_o,
    output logic [5:1]            flags_o
);
    localparam int W      = EXP_W + FRAC_W + 1;
    localparam int N_OPND = 2;

    typedef struct packed {
        logic                     pred;
        logic [W-1:0]             res;
        logic [FLAG_HI:FLAG_LO]   flags;
    } fpcm_state_t;

    fpcm_state_t st_d, st_q;

    logic [W-1:0] opnd [N_OPND];
    fpcm_class_t  cls  [N_OPND];

    assign opnd[0] = a_i;
    assign opnd[1] = b_i;

    for (genvar g = 0; g < N_OPND; g++) begin : g_cls
        fpcm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .opnd_i (opnd[g]),
            .cls_o  (cls[g])
        );
    end

    logic eq_w, gt_w, a_bef_w, b_bef_w;
    logic [W-1:0] pick_w;
    logic any_nan, any_snan, is_cmp, is_mm;

    fpcm_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_ord (
        .a_i          (a_i),
        .b_i          (b_i),
        .eq_o         (eq_w),
        .gt_o         (gt_w),
        .a_before_b_o (a_bef_w),
        .b_before_a_o (b_bef_w)
    );

    fpcm_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sel (
        .a_i          (a_i),
        .b_i          (b_i),
        .cls_a_i      (cls[0]),
        .cls_b_i      (cls[1]),
        .a_before_b_i (a_bef_w),
        .b_before_a_i (b_bef_w),
        .want_max_i   (op_i == OP_MAX),
        .pick_o       (pick_w)
    );

    always_comb begin
        logic [FLAG_HI:FLAG_LO] new_flags;
        any_nan   = cls[0].is_nan  || cls[1].is_nan;
        any_snan  = cls[0].is_snan || cls[1].is_snan;
        is_cmp    = (op_i == OP_EQ) || (op_i == OP_GT) || (op_i == OP_GE);
        is_mm     = (op_i == OP_MIN) || (op_i == OP_MAX);
        st_d      = st_q;
        new_flags = '0;
        if (valid_i) begin
            case (fpcm_op_e'(op_i))
                OP_EQ:  st_d.pred = !any_nan && eq_w;
                OP_GT:  st_d.pred = !any_nan && gt_w;
                OP_GE:  st_d.pred = !any_nan && (gt_w || eq_w);
                OP_MIN, OP_MAX: begin
                    st_d.res            = pick_w;
                    new_flags[FLAG_INV] = any_snan;
                end
                default: ;
            endcase
        end
        st_d.flags = (flag_clr_i ? '0 : st_q.flags) | new_flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pred_o   = st_q.pred;
    assign result_o = st_q.res;
    assign flags_o  = st_q.flags;

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i && !flag_clr_i |=> $stable(pred_o) && $stable(result_o) && $stable(flags_o));

    p_nan_pred_false_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && is_cmp && any_nan |=> !pred_o);

    p_cmp_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && is_cmp && !flag_clr_i |=> $stable(flags_o));

    p_both_nan_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && is_mm && cls[0].is_nan && cls[1].is_nan |=> &result_o);

    p_snan_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && is_mm && any_snan |=> flags_o[FLAG_INV]);

    p_upper_flags_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> flags_o[FLAG_HI:FLAG_INV+1] == '0);

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_clr_i |=> (flags_o & $past(flags_o)) == $past(flags_o));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr_i && !valid_i |=> flags_o == '0);

    p_cmp_keeps_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && is_cmp |=> $stable(result_o));

endmodule

// File: tb/fpcm_top_tb_top.sv
module fpcm_top_tb_top;

    localparam int EW = 3;
    localparam int FW = 2;
    localparam int W  = EW + FW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic         valid, clr;
    logic [2:0]   op;
    logic [W-1:0] a, b;
    logic         pred;
    logic [W-1:0] res;
    logic [5:1]   flags;

    fpcm_top #(.EXP_W(EW), .FRAC_W(FW)) dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid), .op_i(op), .a_i(a), .b_i(b),
        .flag_clr_i(clr), .pred_o(pred), .result_o(res), .flags_o(flags)
    );

    logic        w_valid, w_clr;
    logic [2:0]  w_op;
    logic [31:0] w_a, w_b, w_res;
    logic        w_pred;
    logic [5:1]  w_flags;

    fpcm_top dut_w_i (
        .clk(clk), .rst_n(rst_n), .valid_i(w_valid), .op_i(w_op), .a_i(w_a), .b_i(w_b),
        .flag_clr_i(w_clr), .pred_o(w_pred), .result_o(w_res), .flags_o(w_flags)
    );

    int total = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit is_nan6(logic [W-1:0] x);
        return x[4:2] == 3'd7 && x[1:0] != 2'd0;
    endfunction

    function automatic bit is_snan6(logic [W-1:0] x);
        return is_nan6(x) && !x[1];
    endfunction

    function automatic real val6(logic [W-1:0] x);
        real m;
        int  e;
        e = int'(x[4:2]);
        if (e == 0) m = real'(x[1:0]) * (2.0 ** (-4));
        else        m = real'(4 + int'(x[1:0])) * (2.0 ** (e - 5));
        return x[5] ? -m : m;
    endfunction

    function automatic logic [W-1:0] mm6(logic [W-1:0] x, logic [W-1:0] y, bit want_max);
        real vx, vy;
        if (is_nan6(x) && is_nan6(y)) return '1;
        if (is_nan6(x)) return y;
        if (is_nan6(y)) return x;
        vx = val6(x);
        vy = val6(y);
        if (vx < vy) return want_max ? y : x;
        if (vy < vx) return want_max ? x : y;
        if (x[5] != y[5]) return (want_max ^ x[5]) ? x : y;
        return x;
    endfunction

    logic         e_pred;
    logic [W-1:0] e_res;
    logic [5:1]   e_flags;

    task automatic run6(input int o, input logic [W-1:0] x, input logic [W-1:0] y, input bit do_clr);
        bit nn;
        @(negedge clk);
        valid = 1'b1; op = 3'(o); a = x; b = y; clr = do_clr;
        nn = is_nan6(x) || is_nan6(y);
        if (do_clr) e_flags = '0;
        case (o)
            0: e_pred = !nn && (val6(x) == val6(y));
            1: e_pred = !nn && (val6(x) >  val6(y));
            2: e_pred = !nn && (val6(x) >= val6(y));
            3, 4: begin
                e_res = mm6(x, y, o == 4);
                if (is_snan6(x) || is_snan6(y)) e_flags[1] = 1'b1;
            end
            default: ;
        endcase
        @(negedge clk);
        valid = 1'b0; clr = 1'b0;
        if (o <= 2) begin
            chk(pred == e_pred, (o == 0) ? "R2 eq" : "R3 gt/ge", 32'(pred), 32'(e_pred));
            chk(res == e_res, "R11 compare kept result", 32'(res), 32'(e_res));
            chk(flags == e_flags, "R4 compare quiet flags", 32'(flags), 32'(e_flags));
        end else begin
            chk(res == e_res, "R5/R6/R7 min-max result", 32'(res), 32'(e_res));
            chk(pred == e_pred, "R11 min-max kept pred", 32'(pred), 32'(e_pred));
            chk(flags == e_flags, "R8/R9 min-max flags", 32'(flags), 32'(e_flags));
        end
    endtask

    task automatic run32(input int o, input logic [31:0] x, input logic [31:0] y,
                         input logic [31:0] exp, input logic [5:1] eflg, input string tag);
        @(negedge clk);
        w_valid = 1'b1; w_op = 3'(o); w_a = x; w_b = y;
        @(negedge clk);
        w_valid = 1'b0;
        if (o <= 2) chk(w_pred == exp[0], tag, 32'(w_pred), exp);
        else        chk(w_res == exp, tag, w_res, exp);
        chk(w_flags == eflg, {tag, " flags"}, 32'(w_flags), 32'(eflg));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        valid = 0; clr = 0; op = 0; a = 0; b = 0;
        w_valid = 0; w_clr = 0; w_op = 0; w_a = 0; w_b = 0;
        e_pred = 0; e_res = 0; e_flags = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(pred == 1'b0, "R1 reset pred", 32'(pred), 0);
        chk(res == '0, "R1 reset result", 32'(res), 0);
        chk(flags == '0, "R1 reset flags", 32'(flags), 0);
        rst_n = 1'b1;

        // exhaustive sweep over the 6-bit format
        for (int o = 0; o < 5; o++)
            for (int x = 0; x < 64; x++)
                for (int y = 0; y < 64; y++)
                    run6(o, W'(x), W'(y), 1'b0);

        // R1 hold with valid low
        @(negedge clk);
        op = 3'd3; a = 6'h04; b = 6'h08;
        repeat (3) @(negedge clk);
        chk(res == e_res && pred == e_pred && flags == e_flags, "R1 hold when idle",
            32'(res), 32'(e_res));

        // R11 reserved codes change nothing
        for (int o = 5; o < 8; o++) begin
            run6(o, 6'h1d, 6'h03, 1'b0);
            chk(res == e_res && pred == e_pred, "R11 reserved op", 32'(res), 32'(e_res));
        end

        // R10 clear alone
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        e_flags = '0;
        chk(flags == '0, "R10 clear", 32'(flags), 0);
        // R10 clear with a signaling NaN min in the same cycle keeps new flag
        run6(3, 6'h1d, 6'h04, 1'b0);
        run6(3, 6'h1d, 6'h04, 1'b1);
        chk(flags == 5'b00001, "R10 clear+new", 32'(flags), 32'h1);
        // R10 clear with a quiet NaN min in the same cycle
        run6(4, 6'h1e, 6'h04, 1'b1);
        chk(flags == '0, "R10 clear+quiet", 32'(flags), 0);

        // single-precision directed checks
        run32(3, 32'h7FC00000, 32'h3F800000, 32'h3F800000, 5'b0, "R6 min one qNaN");
        run32(4, 32'h7FC00000, 32'h3F800000, 32'h3F800000, 5'b0, "R6 max one qNaN");
        run32(3, 32'h7FC00000, 32'h7FC00000, 32'hFFFFFFFF, 5'b0, "R7 min two qNaN");
        run32(4, 32'h7FC00000, 32'h7FC00000, 32'hFFFFFFFF, 5'b0, "R7 max two qNaN");
        run32(0, 32'h7FC00000, 32'h3F800000, 32'h0, 5'b0, "R2 eq qNaN");
        run32(1, 32'h7FC00000, 32'h3F800000, 32'h0, 5'b0, "R3 gt qNaN");
        run32(2, 32'h7FC00000, 32'h3F800000, 32'h0, 5'b0, "R3 ge qNaN");
        run32(0, 32'h00000000, 32'h80000000, 32'h1, 5'b0, "R2 eq signed zeros");
        run32(3, 32'h00000000, 32'h80000000, 32'h80000000, 5'b0, "R5 min signed zeros");
        run32(4, 32'h80000000, 32'h00000000, 32'h00000000, 5'b0, "R5 max signed zeros");
        run32(1, 32'hBF800000, 32'hC0000000, 32'h1, 5'b0, "R3 gt negatives");
        run32(0, 32'h7F800001, 32'h3F800000, 32'h0, 5'b0, "R4 eq sNaN quiet");
        run32(3, 32'h7F800001, 32'h3F800000, 32'h3F800000, 5'b00001, "R8 min sNaN");

        finish_run();
    end

endmodule